// File: doc/BRIEF.md
# Display AUX Request Framer

This block sits between a link-management controller and a byte-level AUX PHY model. It accepts one transaction request at a time: a command nibble, a 20-bit target address, a payload length and, for writes, the payload bytes. It checks the request, emits the four-byte request header followed by any write payload as a byte stream, and then waits for the reply status from the PHY side. From the status byte and the returned data count it derives an error class, a byte count and the reply nibble, and reports all three in a one-cycle completion pulse.

A request that breaks the size limits or carries an unsupported command is refused at once. Nothing is sent on the byte stream, and the completion pulse reports the refusal. Only one transaction is in flight at a time. The request port reopens only after the completion pulse.

Top module: `aux_req_framer`

## Requirements
- R1: Header byte 0 is address[7:0] and byte 1 is address[15:8]. Byte 2 is {command[3:0], address[19:16]}. Command codes: native write 4'h8, native read 4'h9, I2C write 4'h0, I2C read 4'h1, I2C write-status-update 4'h2. Command bit 2 (4'h4) is the middle-of-transaction flag.
- R2: Header byte 3 bits [3:0] carry length-1 for a nonzero length and 0 for a zero length.
- R3: For a write, byte 3 bits [7:4] carry (4 + length) modulo 16, so a 12-byte write encodes 0 there. A zero-length write carries 3 there. The payload bytes follow the header in arrival order, and tx_last_o marks the final byte of the stream.
- R4: For a read, only the four header bytes are sent, with tx_last_o on byte 3. Byte 3 bits [7:4] carry 4, or 3 for a zero length.
- R5: Any request longer than 16 bytes is refused with err_o = 3 (too big). A write longer than 12 bytes is also refused with err_o = 3.
- R6: A command whose value with bit 2 cleared is not one of the five codes is refused with err_o = 4 (invalid). Bit 2 never affects this classification. The length check of R5 takes precedence.
- R7: For a refused request, done_o is high in the cycle after the request is accepted, and no byte is emitted. req_ready_o is high again one cycle later.
- R8: A status byte equal to 8'h01 completes with err_o = 1 (timeout). Status 8'h02 or 8'h03 completes with err_o = 2 (I/O error). In both cases count_o and reply_o are 0.
- R9: Any other status completes with err_o = 0 and reply_o = status[7:4]. count_o is the requested length for a write, and min(returned count, requested length) for a read.
- R10: req_ready_o stays low from acceptance until the completion pulse. done_o rises in the cycle after rsp_valid_i is sampled during the wait for a reply. rsp_valid_i has no effect when no reply is awaited.
- R11: While tx_valid_o is high and tx_ready_i is low, tx_valid_o and tx_data_o hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_cmd_i | input | 4 | Request command nibble |
| req_addr_i | input | 20 | Target address |
| req_len_i | input | 5 | Payload length in bytes |
| pld_valid_i | input | 1 | Write payload byte present |
| pld_ready_o | output | 1 | Payload byte taken |
| pld_data_i | input | 8 | Write payload byte |
| tx_valid_o | output | 1 | Stream byte present |
| tx_ready_i | input | 1 | PHY model takes the stream byte |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of the request stream |
| rsp_valid_i | input | 1 | Reply status present |
| rsp_status_i | input | 8 | Reply status byte |
| rsp_count_i | input | 5 | Data byte count returned by the PHY |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 too big, 4 invalid |
| count_o | output | 5 | Byte count of the completed transfer |
| reply_o | output | 4 | Reply nibble on success |

## Verification
Stream bytes are due from the cycle after acceptance. The monitor takes each byte in the cycle where valid and ready are both high, and compares it with the next entry in the expected queue. A refusal must show done_o exactly one cycle after the accepting edge. A reply must show done_o one cycle after the edge that samples rsp_valid_i. The driver samples at the falling edge just after each of those edges and checks done_o there, then checks req_ready_o one cycle later. Backpressure with a fixed pattern on tx_ready_i stretches the stream, and a stall check compares each stalled byte with the byte seen in the next cycle.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  localparam int ADDR_W = 20;

  localparam logic [3:0] CMD_NAT_WR  = 4'h8;
  localparam logic [3:0] CMD_NAT_RD  = 4'h9;
  localparam logic [3:0] CMD_I2C_WR  = 4'h0;
  localparam logic [3:0] CMD_I2C_RD  = 4'h1;
  localparam logic [3:0] CMD_I2C_WSU = 4'h2;
  localparam logic [3:0] MOT_MASK    = 4'h4;

  typedef enum logic [2:0] {
    AUX_OK      = 3'd0,
    AUX_TIMEOUT = 3'd1,
    AUX_IO      = 3'd2,
    AUX_TOO_BIG = 3'd3,
    AUX_INVALID = 3'd4
  } aux_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REJECT, ST_HDR, ST_PLD, ST_WAIT, ST_RESP
  } aux_st_e;
endpackage

// File: rtl/aux_req_check.sv
module aux_req_check
  import aux_req_pkg::*;
#(
  parameter int LEN_W  = 5,
  parameter int MAX_WR = 12,
  parameter int MAX_RD = 16
) (
  input  logic [3:0]       cmd_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             is_write_o,
  output logic             reject_o,
  output aux_err_e         code_o
);
  logic [3:0] base;
  logic       is_read;

  assign base = cmd_i & ~MOT_MASK;

  always_comb begin
    is_write_o = (base == CMD_NAT_WR) || (base == CMD_I2C_WR) || (base == CMD_I2C_WSU);
    is_read    = (base == CMD_NAT_RD) || (base == CMD_I2C_RD);
    if (len_i > LEN_W'(MAX_RD))                    code_o = AUX_TOO_BIG;
    else if (!is_write_o && !is_read)              code_o = AUX_INVALID;
    else if (is_write_o && len_i > LEN_W'(MAX_WR)) code_o = AUX_TOO_BIG;
    else                                           code_o = AUX_OK;
    reject_o = (code_o != AUX_OK);
  end

  always_comb begin
    assert_rej_class_R6: assert (!reject_o || code_o == AUX_TOO_BIG || code_o == AUX_INVALID);
  end
endmodule

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack
  import aux_req_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              is_write_i,
  input  logic [1:0]        idx_i,
  output logic [7:0]        byte_o
);
  localparam int HDR_BYTES = 4;
  localparam logic [3:0] BARE_CNT = 4'd3;

  logic [7:0] hdr [HDR_BYTES];
  logic [3:0] lo_nib, hi_nib;

  // low address bytes
  for (genvar b = 0; b < 2; b++) begin : g_addr
    assign hdr[b] = addr_i[8*b +: 8];
  end

  assign hdr[2] = {cmd_i, addr_i[19:16]};

  always_comb begin
    lo_nib = (len_i == '0) ? 4'd0 : 4'(len_i - 1'b1);
    if (len_i == '0)     hi_nib = BARE_CNT;
    else if (is_write_i) hi_nib = 4'(HDR_BYTES) + 4'(len_i); // wraps at 16
    else                 hi_nib = 4'(HDR_BYTES);
  end

  assign hdr[3] = {hi_nib, lo_nib};
  assign byte_o = hdr[idx_i];
endmodule

// File: rtl/aux_rsp_decode.sv
module aux_rsp_decode
  import aux_req_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [7:0]       status_i,
  input  logic [LEN_W-1:0] rcount_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             is_write_i,
  output aux_err_e         err_o,
  output logic [LEN_W-1:0] count_o,
  output logic [3:0]       reply_o
);
  always_comb begin
    err_o   = AUX_OK;
    count_o = '0;
    reply_o = '0;
    unique case (status_i)
      8'h01:        err_o = AUX_TIMEOUT;
      8'h02, 8'h03: err_o = AUX_IO;
      default: begin
        reply_o = status_i[7:4];
        if (is_write_i)          count_o = len_i;
        else if (rcount_i > len_i) count_o = len_i;
        else                     count_o = rcount_i;
      end
    endcase
  end

  always_comb begin
    assert_err_zero_cnt_R8: assert (err_o == AUX_OK || (count_o == '0 && reply_o == '0));
  end
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_req_pkg::*;
#(
  parameter int LEN_W  = 5,
  parameter int MAX_WR = 12,
  parameter int MAX_RD = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [3:0]       req_cmd_i,
  input  logic [19:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             pld_valid_i,
  output logic             pld_ready_o,
  input  logic [7:0]       pld_data_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_last_o,
  input  logic             rsp_valid_i,
  input  logic [7:0]       rsp_status_i,
  input  logic [LEN_W-1:0] rsp_count_i,
  output logic             done_o,
  output logic [2:0]       err_o,
  output logic [LEN_W-1:0] count_o,
  output logic [3:0]       reply_o
);
  aux_st_e           state_q;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, left_q, cnt_q;
  logic              wr_q;
  logic [1:0]        idx_q;
  aux_err_e          err_q;
  logic [3:0]        rep_q;

  logic       in_is_wr, in_reject;
  aux_err_e   in_code;
  logic [7:0] hdr_byte;
  aux_err_e   d_err;
  logic [LEN_W-1:0] d_cnt;
  logic [3:0] d_rep;
  logic       has_pld;

  aux_req_check #(.LEN_W(LEN_W), .MAX_WR(MAX_WR), .MAX_RD(MAX_RD)) i_check (
    .cmd_i(req_cmd_i), .len_i(req_len_i),
    .is_write_o(in_is_wr), .reject_o(in_reject), .code_o(in_code)
  );

  aux_hdr_pack #(.LEN_W(LEN_W)) i_pack (
    .cmd_i(cmd_q), .addr_i(addr_q), .len_i(len_q), .is_write_i(wr_q),
    .idx_i(idx_q), .byte_o(hdr_byte)
  );

  aux_rsp_decode #(.LEN_W(LEN_W)) i_dec (
    .status_i(rsp_status_i), .rcount_i(rsp_count_i), .len_i(len_q),
    .is_write_i(wr_q), .err_o(d_err), .count_o(d_cnt), .reply_o(d_rep)
  );

  assign has_pld     = wr_q && (len_q != '0);
  assign req_ready_o = (state_q == ST_IDLE);
  assign tx_valid_o  = (state_q == ST_HDR) || ((state_q == ST_PLD) && pld_valid_i);
  assign tx_data_o   = (state_q == ST_HDR) ? hdr_byte : pld_data_i;
  assign tx_last_o   = ((state_q == ST_HDR) && (idx_q == 2'd3) && !has_pld) ||
                       ((state_q == ST_PLD) && pld_valid_i && (left_q == LEN_W'(1)));
  assign pld_ready_o = (state_q == ST_PLD) && tx_ready_i;
  assign done_o      = (state_q == ST_REJECT) || (state_q == ST_RESP);
  assign err_o       = err_q;
  assign count_o     = cnt_q;
  assign reply_o     = rep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      idx_q   <= '0;
      err_q   <= AUX_OK;
      cnt_q   <= '0;
      rep_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          cmd_q   <= req_cmd_i;
          addr_q  <= req_addr_i;
          len_q   <= req_len_i;
          left_q  <= req_len_i;
          wr_q    <= in_is_wr;
          idx_q   <= '0;
          err_q   <= in_code;
          cnt_q   <= '0;
          rep_q   <= '0;
          state_q <= in_reject ? ST_REJECT : ST_HDR;
        end
        ST_REJECT: state_q <= ST_IDLE;
        ST_HDR: if (tx_ready_i) begin
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) state_q <= has_pld ? ST_PLD : ST_WAIT;
        end
        ST_PLD: if (pld_valid_i && tx_ready_i) begin
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) state_q <= ST_WAIT;
        end
        ST_WAIT: if (rsp_valid_i) begin
          err_q   <= d_err;
          cnt_q   <= d_cnt;
          rep_q   <= d_rep;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !req_ready_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && state_q == ST_HDR) |=> (tx_valid_o && $stable(tx_data_o)));

  assert_rej_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (err_o == AUX_TOO_BIG || err_o == AUX_INVALID)) |->
      ($past(req_valid_i && req_ready_o) && !tx_valid_o));

  assert_timeout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == AUX_TIMEOUT) |-> ($past(rsp_valid_i) && $past(rsp_status_i) == 8'h01));

  assert_cnt_clip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == AUX_OK) |-> (count_o <= len_q));

  assert_last_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);
endmodule

// File: tb/test_aux_req_framer.sv
module test_aux_req_framer;
  localparam int LEN_W = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [3:0] req_cmd_i = '0;
  logic [19:0] req_addr_i = '0;
  logic [LEN_W-1:0] req_len_i = '0;
  logic pld_valid_i = 1'b0;
  logic pld_ready_o;
  logic [7:0] pld_data_i = '0;
  logic tx_valid_o;
  logic tx_ready_i = 1'b1;
  logic [7:0] tx_data_o;
  logic tx_last_o;
  logic rsp_valid_i = 1'b0;
  logic [7:0] rsp_status_i = '0;
  logic [LEN_W-1:0] rsp_count_i = '0;
  logic done_o;
  logic [2:0] err_o;
  logic [LEN_W-1:0] count_o;
  logic [3:0] reply_o;

  always #4 clk_i = ~clk_i; // 125 MHz

  aux_req_framer i_aux_req_framer (.*);

  int vectors = 0, misses = 0, cyc = 0, tx_pending = 0;
  bit bp = 1'b0, fin = 1'b0;
  logic [8:0]  tx_q[$];
  logic [11:0] res_q[$];
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      misses++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  always @(posedge clk_i) begin
    #1;
    tx_ready_i = bp ? ((cyc % 3) != 2) : 1'b1;
  end

  // monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (prev_stall)
      chk(tx_valid_o && tx_data_o == prev_data, "R11", {tx_valid_o, tx_data_o}, {1'b1, prev_data});
    if (tx_valid_o) chk(!req_ready_o, "R10", req_ready_o, 0);
    if (tx_valid_o && tx_ready_i) begin
      if (tx_q.size() == 0) chk(1'b0, "R1/R3/R4 extra byte", tx_data_o, 0);
      else begin
        logic [8:0] e;
        e = tx_q.pop_front();
        chk({tx_last_o, tx_data_o} == e, "R1/R2/R3/R4", {tx_last_o, tx_data_o}, e);
        tx_pending--;
      end
    end
    if (done_o) begin
      if (res_q.size() == 0) chk(1'b0, "R10 spurious done", 1, 0);
      else begin
        logic [11:0] r;
        r = res_q.pop_front();
        chk({err_o, count_o, reply_o} == r, "R5/R6/R8/R9", {err_o, count_o, reply_o}, r);
      end
    end
    prev_stall = tx_valid_o && !tx_ready_i;
    prev_data  = tx_data_o;
  end

  task automatic do_req(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                        input logic [7:0] st, input int rcnt);
    logic [3:0] base;
    bit is_wr, is_rd;
    int err, cnt, rep;
    logic [3:0] hi, lo;
    base  = cmd & 4'hB;
    is_wr = (base == 4'h8) || (base == 4'h0) || (base == 4'h2);
    is_rd = (base == 4'h9) || (base == 4'h1);
    if (len > 16) err = 3;
    else if (!is_wr && !is_rd) err = 4;
    else if (is_wr && len > 12) err = 3;
    else err = 0;
    cnt = 0; rep = 0;
    if (err == 0) begin
      if (st == 8'h01) err = 1;
      else if (st == 8'h02 || st == 8'h03) err = 2;
      else begin
        rep = st[7:4];
        cnt = is_wr ? len : (rcnt > len ? len : rcnt);
      end
    end
    res_q.push_back({3'(err), 5'(cnt), 4'(rep)});
    if (!(len > 16 || (!is_wr && !is_rd) || (is_wr && len > 12))) begin
      lo = (len == 0) ? 4'd0 : 4'(len - 1);
      hi = (len == 0) ? 4'd3 : (is_wr ? 4'(4 + len) : 4'd4);
      tx_q.push_back({1'b0, addr[7:0]});
      tx_q.push_back({1'b0, addr[15:8]});
      tx_q.push_back({1'b0, cmd, addr[19:16]});
      tx_q.push_back({!(is_wr && len > 0), hi, lo});
      if (is_wr) for (int i = 0; i < len; i++)
        tx_q.push_back({i == len - 1, 8'(addr[7:0] + 8'(i * 37))});
      tx_pending = tx_q.size();
    end
    @(posedge clk_i); #1;
    req_valid_i = 1'b1; req_cmd_i = cmd; req_addr_i = addr; req_len_i = LEN_W'(len);
    do @(negedge clk_i); while (!req_ready_o);
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    if (tx_pending == 0) begin
      @(negedge clk_i);
      chk(done_o == 1'b1 && !tx_valid_o, "R7 reject timing", {done_o, tx_valid_o}, 2'b10);
      @(negedge clk_i);
      chk(req_ready_o == 1'b1, "R7 ready after reject", req_ready_o, 1);
    end else begin
      if (is_wr) for (int i = 0; i < len; i++) begin
        pld_valid_i = 1'b1;
        pld_data_i  = 8'(addr[7:0] + 8'(i * 37));
        do @(negedge clk_i); while (!pld_ready_o);
        @(posedge clk_i); #1;
      end
      pld_valid_i = 1'b0;
      wait (tx_pending == 0);
      @(posedge clk_i);
      @(negedge clk_i);
      chk(!req_ready_o && !done_o, "R10 busy while waiting", {req_ready_o, done_o}, 0);
      @(posedge clk_i); #1;
      rsp_valid_i = 1'b1; rsp_status_i = st; rsp_count_i = LEN_W'(rcnt);
      @(posedge clk_i); #1;
      rsp_valid_i = 1'b0;
      @(negedge clk_i);
      chk(done_o == 1'b1, "R10 done timing", done_o, 1);
      @(negedge clk_i);
      chk(req_ready_o == 1'b1 && !done_o, "R10 ready after done", {req_ready_o, done_o}, 2'b10);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !tx_valid_o && !done_o, "reset", {req_ready_o, tx_valid_o, done_o}, 3'b100);

    do_req(4'h8, 20'h12345, 3, 8'h00, 0);   // R1 R3 native write
    do_req(4'h9, 20'hABCDE, 4, 8'h00, 9);   // R4 R9 read clipped
    do_req(4'h4, 20'h00050, 0, 8'h00, 0);   // R3 address-only write, MOT
    do_req(4'h1, 20'h00050, 0, 8'h00, 5);   // R4 address-only read
    bp = 1'b1;
    do_req(4'h5, 20'h00A50, 8, 8'h10, 3);   // R9 reply nibble, backpressure
    do_req(4'h2, 20'hF0F0F, 12, 8'h00, 0);  // R3 nibble wraps to 0
    do_req(4'hC, 20'h7E001, 5, 8'h20, 0);   // R6 MOT on native write
    do_req(4'h9, 20'h00200, 16, 8'h01, 16); // R8 timeout, R2 len 16
    bp = 1'b0;
    do_req(4'hD, 20'h00300, 2, 8'h02, 2);   // R8 io
    do_req(4'h1, 20'h00301, 2, 8'h03, 2);   // R8 io
    do_req(4'h8, 20'h00400, 13, 8'h00, 0);  // R5 write too big
    do_req(4'h9, 20'h00400, 17, 8'h00, 0);  // R5 read too big
    do_req(4'hA, 20'h00500, 2, 8'h00, 0);   // R6 invalid
    do_req(4'h3, 20'h00500, 1, 8'h00, 0);   // R6 invalid
    do_req(4'hF, 20'h00500, 20, 8'h00, 0);  // R5 precedence over R6

    // R10: reply status ignored while idle
    @(posedge clk_i); #1;
    rsp_valid_i = 1'b1; rsp_status_i = 8'h01;
    @(posedge clk_i); #1;
    rsp_valid_i = 1'b0;
    @(negedge clk_i);
    chk(!done_o && req_ready_o, "R10 idle reply ignored", {done_o, req_ready_o}, 2'b01);
    @(negedge clk_i);
    chk(!done_o, "R10 idle reply ignored", done_o, 0);
    do_req(4'h0, 20'h00777, 1, 8'h00, 0);   // R9 state intact afterwards

    chk(res_q.size() == 0 && tx_q.size() == 0, "R7/R10 queues drained", res_q.size(), 0);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule